// File: doc/BRIEF.md
# Two-Pin General-Purpose Port with Output Latch and Pullup Control

This block drives a two-pin general-purpose I/O port. It holds a per-pin output-data latch and a per-pin direction bit. It also synchronizes the pin levels so that they can be read back. All three are 8-bit locations on a simple peripheral bus. In each of them only the low two bits are implemented.

The direction bit gives each output-data bit one of two meanings:

- **Output mode:** the bit is the value driven onto the pad.
- **Input mode:** the pad is released and the same bit turns on the pin's weak pullup.

The stored data therefore survives any number of direction changes. Software can preset a level before it turns a pin into an output. The pullup state of an input is kept across trips through output mode.

The bus has one enable, one write strobe, a 2-bit address and 8-bit data in each direction:

| Address | Location | Access |
|---------|----------|--------|
| 0 | Output-data latch | read/write |
| 1 | Direction register | read/write |
| 2 | Synchronized pin input | read-only |
| 3 | Unmapped | reads 0 |

A write is taken on the clock edge where the enable and the write strobe are both high. Read data is combinational from the address.

Top module: `gpio_port_top`

## Requirements
- R1: After reset, the output-data location (address 0) reads 8'h03 and the direction location (address 1) reads 8'h00. With all pins as inputs, pad_pu is 2'b11, pad_oe is 2'b00 and pad_out is 2'b00.
- R2: In the output-data location, bits 7..2 always read 0, and writes to those bits are ignored. Bits 1..0 take the written value on the clock edge of the write.
- R3: A pin whose direction bit is 1 (output) has pad_oe high, has pad_out equal to its output-data bit, and has pad_pu low.
- R4: A pin whose direction bit is 0 (input) has pad_oe low and pad_out low, and pad_pu equals its output-data bit.
- R5: A write to the direction location never changes the stored output-data bits.
- R6: In the direction location, bits 1..0 are implemented. Bits 7..2 read 0, and writes to them are ignored.
- R7: The input location (address 2) returns the pin levels through a two-flop synchronizer. A change on pin_in appears in the read data after exactly two rising clock edges, in bits 1..0, with bits 7..2 at 0.
- R8: Writes to address 2 and address 3 change no stored state, and address 3 reads 0.
- R9: A write with bus_en low has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access enable |
| bus_wr | input | 1 | Write strobe, qualified by bus_en |
| bus_addr | input | 2 | Location select: 0 data, 1 direction, 2 input, 3 unmapped |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pin_in | input | 2 | Asynchronous pin levels from the pads |
| pad_oe | output | 2 | Per-pin output enable |
| pad_out | output | 2 | Per-pin driven value |
| pad_pu | output | 2 | Per-pin weak-pullup enable |

## Verification
The hardest situation to reach is a direction change on a pin whose latch holds a value that differs from what the other mode would expect.

For example, a pin may hold a 0 while it is an output and then become an input, which must leave its pullup off. Another pin may hold a 1 and flip the other way, which must turn its pullup off and drive it high.

The stimulus table walks every pairing of direction and data across the two pins. Each entry first writes the data with junk in the reserved bits, then writes the direction. It then reads the latch back to show that the direction write left it intact.

Synchronizer latency is checked by changing pin_in between edges and reading the input location after one edge and again after two.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    parameter int PIN_W  = 2;
    parameter int DATA_W = 8;
    parameter int ADDR_W = 2;

    localparam logic [ADDR_W-1:0] LOC_DATA = 2'd0;
    localparam logic [ADDR_W-1:0] LOC_DIR  = 2'd1;
    localparam logic [ADDR_W-1:0] LOC_PIN  = 2'd2;

    localparam logic [PIN_W-1:0] DATA_RST = '1;
    localparam logic [PIN_W-1:0] DIR_RST  = '0;

    typedef struct packed {
        logic [PIN_W-1:0] odata;
        logic [PIN_W-1:0] dir;
    } port_state_t;

endpackage

// File: rtl/gpio_port_sync.sv
module gpio_port_sync
    import gpio_port_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_sync
);

    typedef logic [STAGES-1:0][PIN_W-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d = chain_q;
        chain_d[0] = pin_in;
        for (int s = 1; s < STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_sync = chain_q[STAGES-1];

    // Checker state: marks that one full cycle out of reset has elapsed.
    logic warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) warm_q <= 1'b0;
        else        warm_q <= 1'b1;
    end

    assert_first_stage_R7: assert property (@(posedge clk) disable iff (!rst_n)
        warm_q |-> chain_q[0] == $past(pin_in));

    generate
        for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
            assert_stage_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
                warm_q |-> chain_q[g] == $past(chain_q[g-1]));
        end
    endgenerate

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [PIN_W-1:0]  pin_sync,
    output logic [PIN_W-1:0]  odata,
    output logic [PIN_W-1:0]  dir,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int PAD_W = DATA_W - PIN_W;

    port_state_t st_d, st_q;
    logic        wr_data, wr_dir;

    assign wr_data = bus_en && bus_wr && (bus_addr == LOC_DATA);
    assign wr_dir  = bus_en && bus_wr && (bus_addr == LOC_DIR);

    always_comb begin
        st_d = st_q;
        if (wr_data) st_d.odata = bus_wdata[PIN_W-1:0];
        if (wr_dir)  st_d.dir   = bus_wdata[PIN_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.odata <= DATA_RST;
            st_q.dir   <= DIR_RST;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (bus_addr)
            LOC_DATA: bus_rdata = {{PAD_W{1'b0}}, st_q.odata};
            LOC_DIR:  bus_rdata = {{PAD_W{1'b0}}, st_q.dir};
            LOC_PIN:  bus_rdata = {{PAD_W{1'b0}}, pin_sync};
            default:  bus_rdata = '0;
        endcase
    end

    assign odata = st_q.odata;
    assign dir   = st_q.dir;

    assert_reset_value_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (odata == DATA_RST && dir == DIR_RST));

    assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[DATA_W-1:PIN_W] == '0);

    assert_dir_write_keeps_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr == LOC_DIR) |=> $stable(odata));

    assert_idle_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> ($stable(odata) && $stable(dir)));

    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && bus_wr && bus_addr[1]) |=> ($stable(odata) && $stable(dir)));

endmodule

// File: rtl/gpio_port_pads.sv
module gpio_port_pads
    import gpio_port_pkg::*;
(
    input  logic [PIN_W-1:0] odata,
    input  logic [PIN_W-1:0] dir,
    output logic [PIN_W-1:0] pad_oe,
    output logic [PIN_W-1:0] pad_out,
    output logic [PIN_W-1:0] pad_pu
);

    generate
        for (genvar p = 0; p < PIN_W; p++) begin : g_pin
            always_comb begin
                pad_oe[p]  = dir[p];
                pad_out[p] = dir[p] ? odata[p] : 1'b0;
                pad_pu[p]  = dir[p] ? 1'b0 : odata[p];
            end

            always_comb begin
                assert_no_pull_while_driving_R3: assert (!(pad_oe[p] && pad_pu[p]));
                assert_released_low_R4: assert (pad_oe[p] || !pad_out[p]);
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_port_top.sv
module gpio_port_top
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_en,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [PIN_W-1:0]  pin_in,
    output logic [PIN_W-1:0]  pad_oe,
    output logic [PIN_W-1:0]  pad_out,
    output logic [PIN_W-1:0]  pad_pu
);

    logic [PIN_W-1:0] pin_sync;
    logic [PIN_W-1:0] odata;
    logic [PIN_W-1:0] dir;

    gpio_port_sync #(.STAGES(2)) sync_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_in   (pin_in),
        .pin_sync (pin_sync)
    );

    gpio_port_regs regs_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_en    (bus_en),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_sync  (pin_sync),
        .odata     (odata),
        .dir       (dir),
        .bus_rdata (bus_rdata)
    );

    gpio_port_pads pads_i (
        .odata   (odata),
        .dir     (dir),
        .pad_oe  (pad_oe),
        .pad_out (pad_out),
        .pad_pu  (pad_pu)
    );

endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_top_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_en = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic [1:0] pin_in = 2'b00;
    logic [1:0] pad_oe, pad_out, pad_pu;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    gpio_port_top dut_i (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out), .pad_pu(pad_pu)
    );

    // {dir, odata, exp_oe, exp_out, exp_pu}; dir bit 1 = output
    localparam logic [9:0] VEC [8] = '{
        {2'b00, 2'b11, 2'b00, 2'b00, 2'b11},
        {2'b11, 2'b11, 2'b11, 2'b11, 2'b00},
        {2'b01, 2'b10, 2'b01, 2'b00, 2'b10},
        {2'b10, 2'b10, 2'b10, 2'b10, 2'b00},
        {2'b01, 2'b01, 2'b01, 2'b01, 2'b00},
        {2'b10, 2'b01, 2'b10, 2'b00, 2'b01},
        {2'b11, 2'b00, 2'b11, 2'b00, 2'b00},
        {2'b00, 2'b00, 2'b00, 2'b00, 2'b00}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic en);
        @(negedge clk);
        bus_en = en; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_en = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic check_pads(input string req, input logic [1:0] oe,
                              input logic [1:0] o, input logic [1:0] pu);
        check(req, {2'b00, pad_oe, pad_out, pad_pu}, {2'b00, oe, o, pu});
    endtask

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        bus_read(2'd0, rd); check("R1 data reset", rd, 8'h03);
        bus_read(2'd1, rd); check("R1 dir reset", rd, 8'h00);
        check_pads("R1 pads after reset", 2'b00, 2'b00, 2'b11);

        // Table walk: R2 R3 R4 R5 R6
        for (int i = 0; i < 8; i++) begin
            logic [1:0] vd, vo, eoe, eout, epu;
            {vd, vo, eoe, eout, epu} = VEC[i];
            bus_write(2'd0, {6'b101101, vo}, 1'b1);
            bus_write(2'd1, {6'b110011, vd}, 1'b1);
            #1;
            if (vd == 2'b11) check_pads("R3 output mode pads", eoe, eout, epu);
            else if (vd == 2'b00) check_pads("R4 input mode pads", eoe, eout, epu);
            else check_pads("R3 R4 mixed pads", eoe, eout, epu);
            bus_read(2'd0, rd); check("R5 R2 data kept after dir write", rd, {6'b0, vo});
            bus_read(2'd1, rd); check("R6 dir readback", rd, {6'b0, vd});
        end

        // R7 synchronizer latency
        bus_write(2'd0, 8'h00, 1'b1);
        @(negedge clk);
        pin_in = 2'b10;
        @(negedge clk);
        bus_read(2'd2, rd); check("R7 input after one edge", rd, 8'h00);
        @(negedge clk);
        bus_read(2'd2, rd); check("R7 input after two edges", rd, 8'h02);
        pin_in = 2'b01;
        repeat (2) @(negedge clk);
        bus_read(2'd2, rd); check("R7 input second pattern", rd, 8'h01);

        // R8 writes to input and unmapped locations
        bus_write(2'd1, 8'h01, 1'b1);
        bus_write(2'd0, 8'h02, 1'b1);
        bus_write(2'd2, 8'hFF, 1'b1);
        bus_write(2'd3, 8'hFF, 1'b1);
        bus_read(2'd0, rd); check("R8 data untouched", rd, 8'h02);
        bus_read(2'd1, rd); check("R8 dir untouched", rd, 8'h01);
        bus_read(2'd2, rd); check("R8 input still pins", rd, 8'h01);
        bus_read(2'd3, rd); check("R8 unmapped reads zero", rd, 8'h00);

        // R9 write without enable
        bus_write(2'd0, 8'h01, 1'b0);
        bus_write(2'd1, 8'h02, 1'b0);
        bus_read(2'd0, rd); check("R9 data not written", rd, 8'h02);
        bus_read(2'd1, rd); check("R9 dir not written", rd, 8'h01);
        #1;
        check_pads("R9 pads unchanged", 2'b01, 2'b00, 2'b10);

        // R2 reserved bits all ones ignored
        bus_write(2'd0, 8'hFC, 1'b1);
        bus_read(2'd0, rd); check("R2 reserved write ignored", rd, 8'h00);

        // R1 second reset restores defaults
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        bus_read(2'd0, rd); check("R1 data after re-reset", rd, 8'h03);
        check_pads("R1 pads after re-reset", 2'b00, 2'b00, 2'b11);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule